// File: doc/BRIEF.md
# ECC Control and Status Register for Two FIFO RAMs

This block holds a 9-bit register that controls the error protection of a receive FIFO RAM and a transmit FIFO RAM. Software reaches it through a single-cycle port with a write strobe, write data and combinational read data. The register drives a protection enable. It produces one-cycle error-injection strobes towards the encoders of the two RAMs. It also collects single-bit (correctable) and double-bit (uncorrectable) error events reported by the decoders of the two RAMs.

Each injection control is an ordinary read/write bit. Only a 0-to-1 change of that bit produces a strobe, and the strobe lasts exactly one cycle. The four error status bits are sticky. Hardware sets them, and software clears them by writing 1 to the bit. The interrupt output is high while any status bit is set. While the enable bit is 0, injection edges and error events are dropped. They are not held back for later.

Single-bit strobes ask the RAM's encoder for a correctable one-bit corruption. Double-bit strobes ask it for an uncorrectable two-bit corruption. Producing those corruptions is the encoder's task.

There are no sequential modes. The only state is the register, plus a one-cycle delayed copy of the four injection bits that the edge detector uses.

Top module: `ecc_ctl_csr`

## Requirements
- R1: After reset, all nine register bits read 0. Every injection strobe is low, `ecc_en` is low and `irq` is low.
- R2: A write with `wr_en` high stores `wr_data[0]` as the enable and `wr_data[4:1]` as the injection controls. The controls map as follows: bit 1 is TX single, bit 2 is TX double, bit 3 is RX single, bit 4 is RX double. `ecc_en` follows bit 0.
- R3: `rd_data` returns the enable at bit 0, the injection controls at bits 4:1 and the status at bits 8:5. Every bit above bit 8 reads 0.
- R4: When a write changes an injection bit from 0 to 1 while the enable (after that write) is 1, the matching strobe is high in the cycle after the write. The matching strobe for bit 1 is `inj_tx_sbe`, for bit 2 `inj_tx_dbe`, for bit 3 `inj_rx_sbe` and for bit 4 `inj_rx_dbe`.
- R5: Each strobe lasts exactly one cycle. A write of 1 to an injection bit that already reads 1 gives no strobe.
- R6: While the enable reads 0, error events set no status bit. A 0-to-1 injection edge produces no strobe and is not replayed when the enable later turns on.
- R7: When the enable is 1, an event input that is high in a cycle sets its status bit at that clock edge. The bits are: bit 5 for TX single, bit 6 for TX double, bit 7 for RX single and bit 8 for RX double. A set bit stays set until it is cleared.
- R8: Writing 1 to a status bit position clears that bit. Writing 0 leaves it unchanged.
- R9: When an event sets a status bit in the same cycle that a write clears it, the bit ends up set.
- R10: `irq` is high exactly while at least one of status bits 8:5 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register contents, zero-extended |
| tx_sbe_evt | input | 1 | TX FIFO RAM correctable error event |
| tx_dbe_evt | input | 1 | TX FIFO RAM uncorrectable error event |
| rx_sbe_evt | input | 1 | RX FIFO RAM correctable error event |
| rx_dbe_evt | input | 1 | RX FIFO RAM uncorrectable error event |
| ecc_en | output | 1 | Protection enable |
| inj_tx_sbe | output | 1 | One-cycle single-bit injection strobe, TX RAM |
| inj_tx_dbe | output | 1 | One-cycle double-bit injection strobe, TX RAM |
| inj_rx_sbe | output | 1 | One-cycle single-bit injection strobe, RX RAM |
| inj_rx_dbe | output | 1 | One-cycle double-bit injection strobe, RX RAM |
| irq | output | 1 | High while any status bit is set |

## Verification
A hardware set and a software write-one-clear can fall on the same status bit in the same cycle. The bench provokes this by pulsing an event input during a write that carries a 1 at that bit position, both in directed steps and in a random phase. The bench judges it by the status read back and by `irq` in the following cycle, where the set must have won. The same write can also flip the enable and raise injection bits at once. The model therefore judges each strobe against the enable value that the write leaves behind.

// File: rtl/ecc_csr_pkg.sv
package ecc_csr_pkg;
    localparam int unsigned CSR_W   = 9;
    localparam int unsigned EN_BIT  = 0;
    localparam int unsigned N_CH    = 4;  // 0 tx single, 1 tx double, 2 rx single, 3 rx double
    localparam int unsigned INJ_LO  = 1;
    localparam int unsigned STAT_LO = INJ_LO + N_CH;

    typedef logic [N_CH-1:0] ch_vec_t;
endpackage

// File: rtl/ecc_inj_edge.sv
module ecc_inj_edge #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ctrl,
    input  logic         en,
    output logic [N-1:0] pulse
);
    logic [N-1:0] ctrl_d;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ctrl_d[i] <= 1'b0;
            else        ctrl_d[i] <= ctrl[i];
        end

        assign pulse[i] = ctrl[i] & ~ctrl_d[i] & en;

        // a strobe never lasts longer than one cycle
        assert_pulse_one_cycle_R5: assert property (
            @(posedge clk) disable iff (!rst_n) pulse[i] |=> !pulse[i]);
    end
endmodule

// File: rtl/ecc_sticky_status.sv
module ecc_sticky_status #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] stat
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q <= 1'b0;
            else if (set[i]) q <= 1'b1;
            else if (clr[i]) q <= 1'b0;
        end
        assign stat[i] = q;

        assert_sticky_hold_R7: assert property (
            @(posedge clk) disable iff (!rst_n) (stat[i] && !clr[i]) |=> stat[i]);
        assert_w1c_clears_R8: assert property (
            @(posedge clk) disable iff (!rst_n) (clr[i] && !set[i]) |=> !stat[i]);
        assert_set_wins_R9: assert property (
            @(posedge clk) disable iff (!rst_n) set[i] |=> stat[i]);
    end
endmodule

// File: rtl/ecc_ctl_csr.sv
module ecc_ctl_csr
    import ecc_csr_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              tx_sbe_evt,
    input  logic              tx_dbe_evt,
    input  logic              rx_sbe_evt,
    input  logic              rx_dbe_evt,
    output logic              ecc_en,
    output logic              inj_tx_sbe,
    output logic              inj_tx_dbe,
    output logic              inj_rx_sbe,
    output logic              inj_rx_dbe,
    output logic              irq
);
    localparam int unsigned PAD_W = DATA_W - CSR_W;

    logic    en_q;
    ch_vec_t inj_q;
    ch_vec_t stat;
    ch_vec_t evt;
    ch_vec_t set_v;
    ch_vec_t clr_v;
    ch_vec_t pulse;
    logic    unused_hi;

    assign unused_hi = ^wr_data[DATA_W-1:CSR_W];

    // control storage: enable and injection requests
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            inj_q <= '0;
        end else if (wr_en) begin
            en_q  <= wr_data[EN_BIT];
            inj_q <= wr_data[INJ_LO +: N_CH];
        end
    end

    assign evt   = {rx_dbe_evt, rx_sbe_evt, tx_dbe_evt, tx_sbe_evt};
    assign set_v = evt & {N_CH{en_q}};
    assign clr_v = wr_data[STAT_LO +: N_CH] & {N_CH{wr_en}};

    ecc_inj_edge #(.N(N_CH)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .ctrl  (inj_q),
        .en    (en_q),
        .pulse (pulse)
    );

    ecc_sticky_status #(.N(N_CH)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (set_v),
        .clr   (clr_v),
        .stat  (stat)
    );

    assign ecc_en     = en_q;
    assign inj_tx_sbe = pulse[0];
    assign inj_tx_dbe = pulse[1];
    assign inj_rx_sbe = pulse[2];
    assign inj_rx_dbe = pulse[3];
    assign irq        = |stat;
    assign rd_data    = {{PAD_W{1'b0}}, stat, inj_q, en_q};

    for (genvar i = 0; i < N_CH; i++) begin : g_chk
        // a strobe only follows a write that carried a 1 at that control bit
        assert_pulse_after_write_R4: assert property (
            @(posedge clk) disable iff (!rst_n)
            pulse[i] |-> ($past(wr_en) && $past(wr_data[INJ_LO+i])));
        // status can only rise while the enable was on
        assert_no_set_when_off_R6: assert property (
            @(posedge clk) disable iff (!rst_n)
            $rose(stat[i]) |-> ($past(en_q) && $past(evt[i])));
    end

    // the interrupt only rises after an enabled event
    assert_irq_rise_R10: assert property (
        @(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(en_q) && ($past(evt) != '0)));
endmodule

// File: tb/ecc_ctl_csr_tb_top.sv
module ecc_ctl_csr_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        tx_sbe_evt = 1'b0, tx_dbe_evt = 1'b0, rx_sbe_evt = 1'b0, rx_dbe_evt = 1'b0;
    logic        ecc_en, inj_tx_sbe, inj_tx_dbe, inj_rx_sbe, inj_rx_dbe, irq;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // behavioural model state
    logic [8:0] m_reg = '0;
    logic [3:0] m_prev = '0;

    always #4 clk = ~clk;  // 125 MHz

    ecc_ctl_csr dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .tx_sbe_evt(tx_sbe_evt), .tx_dbe_evt(tx_dbe_evt),
        .rx_sbe_evt(rx_sbe_evt), .rx_dbe_evt(rx_dbe_evt),
        .ecc_en(ecc_en), .inj_tx_sbe(inj_tx_sbe), .inj_tx_dbe(inj_tx_dbe),
        .inj_rx_sbe(inj_rx_sbe), .inj_rx_dbe(inj_rx_dbe), .irq(irq)
    );

    always @(posedge clk) begin
        logic [3:0] ev;
        logic [3:0] st;
        if (!rst_n) begin
            m_reg  <= '0;
            m_prev <= '0;
        end else begin
            ev = {rx_dbe_evt, rx_sbe_evt, tx_dbe_evt, tx_sbe_evt};
            st = m_reg[8:5];
            if (wr_en) st = st & ~wr_data[8:5];
            if (m_reg[0]) st = st | ev;
            m_prev <= m_reg[4:1];
            m_reg  <= {st, (wr_en ? wr_data[4:0] : m_reg[4:0])};
        end
    end

    always @(negedge clk) begin
        logic [3:0] exp_p;
        logic [3:0] got_p;
        if (!done) begin
            exp_p = m_reg[4:1] & ~m_prev & {4{m_reg[0]}};
            got_p = {inj_rx_dbe, inj_rx_sbe, inj_tx_dbe, inj_tx_sbe};
            n_vec++;
            if (rd_data !== {23'b0, m_reg} || ecc_en !== m_reg[0] ||
                got_p !== exp_p || irq !== (|m_reg[8:5])) begin
                n_bad++;
                $display("FAIL %s: rd_data=%h en=%b inj=%b irq=%b expected rd_data=%h en=%b inj=%b irq=%b",
                         cur_req, rd_data, ecc_en, got_p, irq,
                         {23'b0, m_reg}, m_reg[0], exp_p, |m_reg[8:5]);
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic evt(input logic [3:0] e);
        @(negedge clk);
        {rx_dbe_evt, rx_sbe_evt, tx_dbe_evt, tx_sbe_evt} = e;
        @(negedge clk);
        {rx_dbe_evt, rx_sbe_evt, tx_dbe_evt, tx_sbe_evt} = '0;
    endtask

    task automatic wr_evt(input logic [31:0] d, input logic [3:0] e);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        {rx_dbe_evt, rx_sbe_evt, tx_dbe_evt, tx_sbe_evt} = e;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
        {rx_dbe_evt, rx_sbe_evt, tx_dbe_evt, tx_sbe_evt} = '0;
    endtask

    initial begin
        cur_req = "R1";  // reset state
        idle(3);
        rst_n = 1'b1;
        idle(3);

        cur_req = "R2";  // enable and control storage
        wr(32'h0000_0001);
        idle(2);

        cur_req = "R4";  // all four injections at once, then one at a time
        wr(32'h0000_001F);
        idle(2);
        cur_req = "R5";  // rewriting ones: no new strobe
        wr(32'h0000_001F);
        idle(2);
        cur_req = "R4";
        wr(32'h0000_0001);
        wr(32'h0000_0003);
        wr(32'h0000_0005);
        wr(32'h0000_0009);
        wr(32'h0000_0011);
        idle(2);

        cur_req = "R6";  // enable off: edges and events dropped
        wr(32'h0000_0000);
        wr(32'h0000_001E);
        evt(4'hF);
        idle(2);
        wr(32'h0000_001F);  // enable on, controls already 1: nothing replayed
        idle(2);

        cur_req = "R7";  // each event sets its own status bit
        evt(4'b0001);
        evt(4'b0010);
        idle(2);
        evt(4'b0100);
        evt(4'b1000);
        idle(3);

        cur_req = "R8";  // writing 0 leaves status; writing 1 clears only that bit
        wr(32'h0000_0001);
        wr(32'h0000_0021);
        wr(32'h0000_0181);
        cur_req = "R10";
        wr(32'h0000_0041);
        idle(2);

        cur_req = "R9";  // set and clear on the same bit in one cycle
        evt(4'b0101);
        wr_evt(32'h0000_01E1, 4'b0001);
        idle(2);
        wr_evt(32'h0000_01E1, 4'b1000);
        idle(2);

        cur_req = "R3";  // upper bits read zero
        wr(32'hFFFF_FFFF);
        idle(2);
        wr(32'hFFFF_FE00);
        idle(2);

        cur_req = "R9";  // mixed random traffic
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            wr_en   = ($urandom_range(0, 2) == 0);
            wr_data = $urandom;
            {rx_dbe_evt, rx_sbe_evt, tx_dbe_evt, tx_sbe_evt} = 4'($urandom);
        end
        @(negedge clk);
        wr_en = 1'b0;
        {rx_dbe_evt, rx_sbe_evt, tx_dbe_evt, tx_sbe_evt} = '0;
        idle(3);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: %s run did not finish, actual=hung expected=done", cur_req);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule